// File: doc/BRIEF.md
# Nine-Bit Serial Command Writer

This block is a three-wire serial master that delivers register writes to a display controller. Every transfer is built from 9-bit words. The top bit of each word marks it as a command (0) or as data (1), and the low eight bits carry a register address or a data byte. A user request names a register address and one of three shapes: the address alone, the address plus one byte, or the address plus a 16-bit value. The block frames the words, holds the select line low for the whole request and clocks the bits out most significant first.

The serial clock idles high. For each bit the block pulls the clock low, presents the bit on the data line, waits one half-period and raises the clock, so the receiver latches on the rising edge. The half-period is a parameter counted in system clock cycles. A reasonable setting is about 200 µs, and it must never be set below 75 µs. The data line is looped back to a data input. Before each rising edge the block compares that input with the bit it drives. On a mismatch it drops the transfer, returns the bus to idle and reports an error. A one-cycle completion pulse marks the end of every request, whether it succeeded or was aborted.

Top module: `s9w_writer`

## Requirements
- R1: Word format: bit 8 is 0 for the command word and 1 for each data word. Bits 7:0 hold the address (command word) or the data byte. Each word goes out bit 8 first, down to bit 0, one bit per rising edge of `sck` while `cs_n` is low.
- R2: `req_kind` 0 sends one word (the command). `req_kind` 1 sends the command then `req_value[7:0]`. `req_kind` 2 sends the command, then `req_value[15:8]`, then `req_value[7:0]`.
- R3: `req_kind` 3 is handled exactly like `req_kind` 0, as a single command word.
- R4: In idle, and from the first cycle after reset, `cs_n` is 1, `sck` is 1, `mosi` is 0 and `req_ready` is 1.
- R5: `cs_n` stays low from the first bit of a request to its last bit, across word boundaries. `sck` falls only while `cs_n` is low. `mosi` is stable while `sck` is high inside a transfer.
- R6: Every low half and every high half of `sck` lasts `HALF_CYC` system cycles. A request of n bits finishes with `done` visible 2·`HALF_CYC`·n cycles after the accepting clock edge.
- R7: On the last cycle of each low half, `miso` is compared with the driven bit. On a mismatch at bit k (counted from 0 across the request), no further rising edge of `sck` occurs with `cs_n` low, `done` and `err` pulse together, and the pulse appears 2·`HALF_CYC`·k + `HALF_CYC` cycles after the accepting edge.
- R8: `done` is a one-cycle pulse. `err` is high only together with `done`. When `done` is high, `cs_n` and `sck` are already high. After an abort, the next request completes normally.
- R9: A request is taken only on a cycle with `req_valid` and `req_ready` both high. `req_ready` is low from the cycle after acceptance until the transfer ends. `req_valid` raised while busy starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_kind | input | 2 | Request shape: 0 command, 1 with byte, 2 with 16-bit value, 3 as 0 |
| req_addr | input | 8 | Register address for the command word |
| req_value | input | 16 | Data: low byte for shape 1, both bytes for shape 2 |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Readback mismatch, valid with done |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Looped-back data in for per-bit check |

## Verification
A wrong phase or bit counter shows at the ports within one half-period. It appears as a low or high pulse of `sck` of the wrong width, a missing or extra rising edge before `cs_n` rises, or a `done` pulse on the wrong cycle. A bad shift register or frame builder corrupts the captured bit stream at the first wrong bit. The bench compares whole captured streams and completion latencies against values derived from the request, and it forces readback mismatches at the first bit, at a middle bit inside a data word and at the last bit. These cases expose an abort that fires late, fires at the wrong bit or leaves the bus active.

// File: rtl/s9w_pkg.sv
package s9w_pkg;

    localparam int WORD_W    = 9;
    localparam int BYTE_W    = 8;
    localparam int MAX_WORDS = 3;
    localparam int FRAME_W   = WORD_W * MAX_WORDS;
    localparam int IDX_W     = $clog2(FRAME_W);

    typedef enum logic [1:0] {
        K_CMD  = 2'd0,
        K_BYTE = 2'd1,
        K_HALF = 2'd2,
        K_RSVD = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // Left-justified bit frame plus the index of its final bit.
    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [IDX_W-1:0]   last_idx;
    } frame_t;

    function automatic logic [WORD_W-1:0] mk_word(input logic is_data,
                                                   input logic [BYTE_W-1:0] payload);
        return {is_data, payload};
    endfunction

    function automatic logic [IDX_W-1:0] idx_of(input int words);
        return IDX_W'(words * WORD_W - 1);
    endfunction

endpackage

// File: rtl/s9w_frame_builder.sv
module s9w_frame_builder
    import s9w_pkg::*;
(
    input  kind_e                kind,
    input  logic [BYTE_W-1:0]    addr,
    input  logic [2*BYTE_W-1:0]  value,
    output frame_t               frame
);

    logic [WORD_W-1:0] words [MAX_WORDS];

    assign words[0] = mk_word(1'b0, addr);

    always_comb begin
        words[1] = mk_word(1'b1, value[BYTE_W-1:0]);
        words[2] = '0;
        if (kind == K_HALF) begin
            words[1] = mk_word(1'b1, value[2*BYTE_W-1:BYTE_W]);
            words[2] = mk_word(1'b1, value[BYTE_W-1:0]);
        end
    end

    always_comb begin
        frame.bits = '0;
        unique case (kind)
            K_BYTE: begin
                frame.bits     = {words[0], words[1], {WORD_W{1'b0}}};
                frame.last_idx = idx_of(2);
            end
            K_HALF: begin
                frame.bits     = {words[0], words[1], words[2]};
                frame.last_idx = idx_of(3);
            end
            default: begin
                frame.bits     = {words[0], {(2*WORD_W){1'b0}}};
                frame.last_idx = idx_of(1);
            end
        endcase
    end

endmodule

// File: rtl/s9w_half_timer.sv
module s9w_half_timer #(
    parameter int HALF_CYC = 40000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic last
);

    localparam int CW = $clog2(HALF_CYC + 1);
    localparam logic [CW-1:0] TERM = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    assign last = (cnt == TERM);

    always_ff @(posedge clk) begin
        if (rst || clear || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/s9w_bit_engine.sv
module s9w_bit_engine
    import s9w_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  frame_t frame,
    input  logic   phase_last,
    input  logic   miso,
    output logic   idle,
    output logic   done,
    output logic   err,
    output logic   cs_n,
    output logic   sck,
    output logic   mosi
);

    phase_e             phase;
    logic [FRAME_W-1:0] sreg;
    logic [IDX_W-1:0]   left;
    logic               cur_bit;

    assign cur_bit = sreg[FRAME_W-1];
    assign idle    = (phase == PH_IDLE);
    assign cs_n    = idle;
    assign sck     = (phase != PH_LOW);
    assign mosi    = !idle && cur_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            sreg  <= '0;
            left  <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        sreg  <= frame.bits;
                        left  <= frame.last_idx;
                        phase <= PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (phase_last) begin
                        if (miso != cur_bit) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                            err   <= 1'b1;
                        end else begin
                            phase <= PH_HIGH;
                        end
                    end
                end
                PH_HIGH: begin
                    if (phase_last) begin
                        if (left == '0) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            sreg  <= sreg << 1;
                            left  <= left - 1'b1;
                            phase <= PH_LOW;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/s9w_writer.sv
module s9w_writer
    import s9w_pkg::*;
#(
    parameter int HALF_CYC = 40000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_kind,
    input  logic [7:0]  req_addr,
    input  logic [15:0] req_value,
    output logic        done,
    output logic        err,
    output logic        cs_n,
    output logic        sck,
    output logic        mosi,
    input  logic        miso
);

    frame_t frame;
    logic   idle;
    logic   phase_last;
    logic   start;

    assign req_ready = idle;
    assign start     = req_valid && idle;

    s9w_frame_builder u_frame (
        .kind  (kind_e'(req_kind)),
        .addr  (req_addr),
        .value (req_value),
        .frame (frame)
    );

    s9w_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (idle),
        .last  (phase_last)
    );

    s9w_bit_engine u_engine (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .frame      (frame),
        .phase_last (phase_last),
        .miso       (miso),
        .idle       (idle),
        .done       (done),
        .err        (err),
        .cs_n       (cs_n),
        .sck        (sck),
        .mosi       (mosi)
    );

endmodule

// File: rtl/s9w_writer_chk.sv
module s9w_writer_chk #(
    parameter int HALF_CYC = 40000
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic err,
    input logic cs_n,
    input logic sck,
    input logic mosi
);

    int unsigned low_run;

    always_ff @(posedge clk) begin
        if (rst || sck) begin
            low_run <= 0;
        end else begin
            low_run <= low_run + 1;
        end
    end

    assert_idle_levels_R4: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (cs_n && sck && !mosi));

    assert_mosi_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && sck && $past(!cs_n && sck)) |-> $stable(mosi));

    assert_sck_fall_framed_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(sck) |-> !cs_n);

    assert_low_width_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(sck) && !cs_n) |-> (low_run == HALF_CYC));

    assert_abort_in_low_R7: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(!sck && !cs_n));

    assert_done_bus_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && sck));

    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind s9w_writer s9w_writer_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .err       (err),
    .cs_n      (cs_n),
    .sck       (sck),
    .mosi      (mosi)
);

// File: tb/tb_s9w_writer.sv
`timescale 1ns/1ps
module tb_s9w_writer;

    localparam int  H   = 3;
    localparam real PER = 5.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_value = '0;
    logic        done, err, cs_n, sck, mosi, miso;

    logic        fault_en = 1'b0;
    int          fault_bit = 0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [26:0] bits;
        int          n;
        bit          err;
        int          lat;
        realtime     t0;
        string       tag;
    } exp_t;

    exp_t q[$];

    logic [26:0] cap;
    int          capn;
    int          lowlen;
    logic        prev_sck;

    always #(PER/2) clk = ~clk;

    assign miso = mosi ^ (fault_en && (capn == fault_bit));

    s9w_writer #(.HALF_CYC(H)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_value(req_value),
        .done(done), .err(err), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor: samples at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (rst) begin
            cap = '0; capn = 0; lowlen = 0; prev_sck = 1'b1;
        end else begin
            if (!cs_n && !sck) lowlen++;
            if (!prev_sck && sck && !cs_n) begin
                chk(lowlen == H, "R6", "low half width", lowlen, H);
                cap  = {cap[25:0], mosi};
                capn++;
            end
            if (sck) lowlen = 0;
            if (done) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    int lat;
                    e   = q.pop_front();
                    lat = int'(($realtime - e.t0) / PER);
                    chk(capn == e.n, "R2", {e.tag, " bit count"}, capn, e.n);
                    chk(cap == e.bits, "R1", {e.tag, " bit stream"}, cap, e.bits);
                    chk(err == e.err, "R7", {e.tag, " err flag"}, err, e.err);
                    chk(lat == e.lat, e.err ? "R7" : "R6", {e.tag, " latency"}, lat, e.lat);
                    chk(cs_n && sck, "R8", {e.tag, " bus idle at done"}, {cs_n, sck}, 2'b11);
                end
                cap = '0; capn = 0;
            end
            prev_sck = sck;
        end
    end

    // Driver: compute the expected stream from the request and push it.
    task automatic start_req(input logic [1:0] kind, input logic [7:0] addr,
                             input logic [15:0] val, input int fbit, input string tag);
        exp_t e;
        logic [26:0] full;
        int nw, total;
        while (!req_ready) @(negedge clk);
        case (kind)
            2'd1:    begin full = {18'b0, 1'b0, addr, 1'b1, val[7:0]}; nw = 2; end
            2'd2:    begin full = {1'b0, addr, 1'b1, val[15:8], 1'b1, val[7:0]}; nw = 3; end
            default: begin full = {18'b0, 1'b0, addr}; nw = 1; end
        endcase
        total = 9 * nw;
        if (fbit >= 0) begin
            e.n   = fbit;
            e.bits = (fbit == 0) ? 27'd0 : (full >> (total - fbit));
            e.err = 1'b1;
            e.lat = 2 * H * fbit + H;
            fault_en  = 1'b1;
            fault_bit = fbit;
        end else begin
            e.n   = total;
            e.bits = full;
            e.err = 1'b0;
            e.lat = 2 * H * total + 1 - 1;
        end
        e.lat = e.lat + 1;
        e.t0  = $realtime;
        e.tag = tag;
        q.push_back(e);
        req_kind  = kind;
        req_addr  = addr;
        req_value = val;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (q.size() != 0) @(negedge clk);
        fault_en = 1'b0;
    endtask

    task automatic send(input logic [1:0] kind, input logic [7:0] addr,
                        input logic [15:0] val, input int fbit, input string tag);
        start_req(kind, addr, val, fbit, tag);
        wait_done();
    endtask

    initial begin
        #(PER * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4: reset and idle levels
        chk(cs_n == 1'b1, "R4", "cs_n after reset", cs_n, 1);
        chk(sck == 1'b1, "R4", "sck after reset", sck, 1);
        chk(mosi == 1'b0, "R4", "mosi after reset", mosi, 0);
        chk(req_ready == 1'b1, "R4", "ready after reset", req_ready, 1);
        chk(done == 1'b0, "R4", "done after reset", done, 0);

        // R1/R2: the three request shapes
        send(2'd0, 8'h29, 16'h0000, -1, "cmd only");
        send(2'd1, 8'h3A, 16'h00A5, -1, "cmd+byte");
        send(2'd2, 8'hB8, 16'hFFF9, -1, "cmd+half");
        send(2'd2, 8'hC3, 16'h2040, -1, "cmd+half hi first");
        // R3: reserved shape acts as command only
        send(2'd3, 8'h11, 16'hFFFF, -1, "R3 reserved shape");

        // R7: readback mismatch at first, middle and last bit
        send(2'd0, 8'h10, 16'h0000, 0, "R7 abort bit 0");
        send(2'd2, 8'hB5, 16'h5533, 13, "R7 abort bit 13");
        send(2'd2, 8'hD4, 16'h11A4, 26, "R7 abort last bit");
        // R8: normal transfer right after an abort
        send(2'd1, 8'hB0, 16'h0016, -1, "R8 after abort");

        // back-to-back requests
        start_req(2'd1, 8'hBD, 16'h0004, -1, "b2b first");
        start_req(2'd0, 8'h28, 16'h0000, -1, "b2b second");
        wait_done();

        // R9: valid while busy starts nothing
        start_req(2'd1, 8'hBA, 16'h0001, -1, "R9 busy base");
        repeat (20) @(negedge clk);
        chk(req_ready == 1'b0, "R9", "ready low while busy", req_ready, 0);
        req_kind = 2'd2; req_addr = 8'hEC; req_value = 16'h01F0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        begin
            int busy_seen = 0;
            repeat (40) begin
                @(negedge clk);
                if (!cs_n) busy_seen++;
            end
            chk(busy_seen == 0, "R9", "no transfer from busy valid", busy_seen, 0);
        end
        chk(req_ready && cs_n && sck && !mosi, "R4", "idle levels at end",
            {req_ready, cs_n, sck, mosi}, 4'b1110);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule